// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block is the control-flow front end of a five-stage in-order pipeline. It owns the fetch program counter and the register between fetch and decode. It decides conditional branches while they sit in decode. The equality comparison on the two source operands and a separate target adder both live in decode. A taken branch therefore redirects fetch one cycle after it arrives, instead of three cycles later when it reaches the memory stage. Instruction memory and the register file sit outside the block. The block presents a fetch address and receives the fetched word in the same cycle. It presents two source register numbers and receives their values in the same cycle.

Fetch always proceeds sequentially, on the assumption that a branch is not taken. The `delay_mode` input selects what happens to the word already fetched behind a taken branch. In squash mode (`delay_mode` = 0) that word is replaced by a no-op and never issues, which costs one bubble. In delay-slot mode (`delay_mode` = 1) that word issues normally, and the redirect takes effect after it. No operand bypass into decode is provided. A branch whose source register is written by the instruction directly ahead of it, now in execute, therefore waits one cycle.

The decode slot is a four-state machine:
- SL_EMPTY: after reset.
- SL_LIVE: holds a fetched word.
- SL_HELD: a stalled branch is kept in place.
- SL_KILL: holds the no-op left by a squash.

Its transitions are:
- EMPTY→LIVE and KILL→LIVE, unconditional.
- LIVE/HELD→HELD on a dependency stall.
- LIVE/HELD→KILL on a taken branch in squash mode.
- LIVE/HELD→LIVE otherwise.

The fetch-address selector has three choices: SEQ (plus 4), HOLD (during a stall) and TARGET (on a redirect).

Top module: `brdec_unit`

## Requirements
- R1: While `rst_n` is low, `fetch_pc` equals RESET_PC (default 0x1000), and `issue_valid`, `redirect` and `stall` are 0.
- R2: With no redirect and no stall, `fetch_pc` rises by 4 every cycle. A word fetched in one cycle is presented on `issue_instr` the next cycle, with `issue_valid` = 1 and `issue_pc4` = its fetch address + 4.
- R3: Instruction fields are opcode [31:26], first source [25:21], second source [20:16] and immediate [15:0]. Opcode 6'h04 (equal) branches when `rs_val` == `rt_val`. Opcode 6'h05 (not equal) branches when they differ. No other opcode ever asserts `redirect`.
- R4: When `redirect` is 1, the next `fetch_pc` is `issue_pc4` + (sign-extended immediate << 2). When the branch is not taken, the next `fetch_pc` is `issue_pc4` + 4.
- R5: In squash mode, a taken branch asserts `squash`. The next cycle shows `issue_valid` = 0 and `issue_instr` = 0 (no-op).
- R6: In delay-slot mode, the word fetched in the cycle of a taken branch issues the next cycle, and `squash` stays 0.
- R7: A branch in decode stalls when `ex_wr_en` = 1 and `ex_wr_reg` is nonzero and equals either source field. During the stall `stall` = 1, `issue_valid` = 0 and `redirect` = 0, and at the next edge `fetch_pc` and the decode contents are unchanged. Register 0 never causes a stall.
- R8: A non-branch instruction in decode never stalls, whatever `ex_wr_reg` holds.
- R9: `rs_addr` and `rt_addr` equal bits [25:21] and [20:16] of the word in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| delay_mode | input | 1 | 0 = squash behind a taken branch, 1 = one delay slot |
| imem_data | input | 32 | Word fetched at `fetch_pc` this cycle |
| rs_val | input | DATA_W | Register value for `rs_addr` |
| rt_val | input | DATA_W | Register value for `rt_addr` |
| ex_wr_en | input | 1 | Instruction in execute will write a register |
| ex_wr_reg | input | 5 | Destination of the instruction in execute |
| fetch_pc | output | PC_W | Current fetch address |
| rs_addr | output | 5 | First source register of the decode word |
| rt_addr | output | 5 | Second source register of the decode word |
| issue_valid | output | 1 | Decode word passes to execute this cycle |
| issue_instr | output | 32 | Word held in decode |
| issue_pc4 | output | PC_W | Fetch address of the decode word + 4 |
| redirect | output | 1 | Taken branch resolved this cycle |
| squash | output | 1 | Fetched successor is being discarded |
| stall | output | 1 | Decode held for a source dependency |

## Verification
The hardest situation to reach is a branch that first stalls on a dependency and is then taken on its release cycle. During the stall the fetched successor must be held, and on release it must be either discarded or issued as a delay slot. The stimulus reaches it by loading a branch and driving the write port of the stage ahead with each destination register 0 to 7 against source pairs 0 to 3. It then drops the write port one cycle later, with the mode alternating across the sweep. Target arithmetic is covered by sweeping immediates that include 0, ±1 and both 16-bit extremes, across both conditions, a non-branch opcode, operand equality and both modes.

// File: rtl/brdec_pkg.sv
`timescale 1ns/1ps
package brdec_pkg;
    localparam int INSN_W  = 32;
    localparam int OPC_W   = 6;
    localparam int REG_AW  = 5;
    localparam int IMM_W   = 16;
    localparam int IMM_SHIFT = 2;

    localparam logic [OPC_W-1:0]  OPC_BR_EQ = 6'h04;
    localparam logic [OPC_W-1:0]  OPC_BR_NE = 6'h05;
    localparam logic [INSN_W-1:0] NOP_WORD  = '0;

    typedef enum logic [1:0] {
        SL_EMPTY,
        SL_LIVE,
        SL_HELD,
        SL_KILL
    } slot_e;

    typedef enum logic [1:0] {
        NPC_SEQ,
        NPC_HOLD,
        NPC_TARGET
    } npc_sel_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [REG_AW-1:0] src_a;
        logic [REG_AW-1:0] src_b;
        logic [IMM_W-1:0]  imm;
    } insn_fields_t;
endpackage

// File: rtl/brdec_cond.sv
`timescale 1ns/1ps
module brdec_cond
    import brdec_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int DATA_W = 32
) (
    input  logic [OPC_W-1:0]  opc,
    input  logic [IMM_W-1:0]  imm,
    input  logic [PC_W-1:0]   pc4,
    input  logic [DATA_W-1:0] val_a,
    input  logic [DATA_W-1:0] val_b,
    output logic              is_branch,
    output logic              cond_true,
    output logic [PC_W-1:0]   target
);
    localparam int EXT_W = PC_W - IMM_W;

    logic            operands_eq;
    logic [PC_W-1:0] offset;

    // Zero-difference test done in decode, not in execute.
    assign operands_eq = (val_a == val_b);
    assign is_branch   = (opc == OPC_BR_EQ) || (opc == OPC_BR_NE);

    always_comb begin
        unique case (opc)
            OPC_BR_EQ: cond_true = operands_eq;
            OPC_BR_NE: cond_true = !operands_eq;
            default:   cond_true = 1'b0;
        endcase
    end

    // Dedicated adder: word-scaled, sign-extended displacement.
    assign offset = {{EXT_W{imm[IMM_W-1]}}, imm} << IMM_SHIFT;
    assign target = pc4 + offset;
endmodule

// File: rtl/brdec_hazard.sv
`timescale 1ns/1ps
module brdec_hazard
    import brdec_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic              slot_live,
    input  logic              is_branch,
    input  logic [REG_AW-1:0] src_a,
    input  logic [REG_AW-1:0] src_b,
    input  logic              ex_wr_en,
    input  logic [REG_AW-1:0] ex_wr_reg,
    output logic              dep_stall
);
    logic [REG_AW-1:0] srcs [NSRC];
    logic [NSRC-1:0]   hit;

    assign srcs[0] = src_a;
    assign srcs[1] = src_b;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = ex_wr_en && (ex_wr_reg != '0) && (ex_wr_reg == srcs[i]);
    end

    // Decode has no bypass path; only branches read operands here.
    assign dep_stall = slot_live && is_branch && (|hit);
endmodule

// File: rtl/brdec_fetch.sv
`timescale 1ns/1ps
module brdec_fetch
    import brdec_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  npc_sel_e        sel,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(INSN_W / 8);

    logic [PC_W-1:0] pc_next;

    // Single next-PC selector: only one source updates the PC per cycle.
    always_comb begin
        unique case (sel)
            NPC_HOLD:   pc_next = pc;
            NPC_TARGET: pc_next = target;
            default:    pc_next = pc + PC_STEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc <= RESET_PC;
        else        pc <= pc_next;
    end
endmodule

// File: rtl/brdec_unit.sv
`timescale 1ns/1ps
module brdec_unit
    import brdec_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter int              DATA_W   = 32,
    parameter logic [PC_W-1:0] RESET_PC = PC_W'(32'h0000_1000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              delay_mode,
    input  logic [INSN_W-1:0] imem_data,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    input  logic              ex_wr_en,
    input  logic [REG_AW-1:0] ex_wr_reg,
    output logic [PC_W-1:0]   fetch_pc,
    output logic [REG_AW-1:0] rs_addr,
    output logic [REG_AW-1:0] rt_addr,
    output logic              issue_valid,
    output logic [INSN_W-1:0] issue_instr,
    output logic [PC_W-1:0]   issue_pc4,
    output logic              redirect,
    output logic              squash,
    output logic              stall
);
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(INSN_W / 8);

    slot_e             slot_q;
    slot_e             slot_d;
    logic [INSN_W-1:0] insn_q;
    logic [PC_W-1:0]   pc4_q;
    insn_fields_t      fld;
    logic              slot_live;
    logic              is_branch;
    logic              cond_true;
    logic              dep_stall;
    logic              take;
    logic [PC_W-1:0]   br_target;
    npc_sel_e          npc_sel;

    assign fld       = insn_fields_t'(insn_q);
    assign slot_live = (slot_q == SL_LIVE) || (slot_q == SL_HELD);

    brdec_cond #(
        .PC_W   (PC_W),
        .DATA_W (DATA_W)
    ) u_cond (
        .opc       (fld.opc),
        .imm       (fld.imm),
        .pc4       (pc4_q),
        .val_a     (rs_val),
        .val_b     (rt_val),
        .is_branch (is_branch),
        .cond_true (cond_true),
        .target    (br_target)
    );

    brdec_hazard #(
        .NSRC (2)
    ) u_hazard (
        .slot_live (slot_live),
        .is_branch (is_branch),
        .src_a     (fld.src_a),
        .src_b     (fld.src_b),
        .ex_wr_en  (ex_wr_en),
        .ex_wr_reg (ex_wr_reg),
        .dep_stall (dep_stall)
    );

    assign take = slot_live && is_branch && cond_true && !dep_stall;

    // Next-state logic of the decode slot.
    always_comb begin
        unique case (slot_q)
            SL_EMPTY: slot_d = SL_LIVE;
            SL_KILL:  slot_d = SL_LIVE;
            SL_LIVE, SL_HELD: begin
                if (dep_stall)                 slot_d = SL_HELD;
                else if (take && !delay_mode)  slot_d = SL_KILL;
                else                           slot_d = SL_LIVE;
            end
            default:  slot_d = SL_EMPTY;
        endcase
    end

    // State register with the slot payload it governs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= SL_EMPTY;
            insn_q <= NOP_WORD;
            pc4_q  <= '0;
        end else begin
            slot_q <= slot_d;
            unique case (slot_d)
                SL_HELD: begin
                    insn_q <= insn_q;
                    pc4_q  <= pc4_q;
                end
                SL_KILL: begin
                    insn_q <= NOP_WORD;
                    pc4_q  <= fetch_pc + PC_STEP;
                end
                default: begin
                    insn_q <= imem_data;
                    pc4_q  <= fetch_pc + PC_STEP;
                end
            endcase
        end
    end

    // Outputs of the machine.
    always_comb begin
        issue_valid = slot_live && !dep_stall;
        redirect    = take;
        squash      = take && !delay_mode;
        stall       = dep_stall;
        if (dep_stall)  npc_sel = NPC_HOLD;
        else if (take)  npc_sel = NPC_TARGET;
        else            npc_sel = NPC_SEQ;
    end

    assign issue_instr = insn_q;
    assign issue_pc4   = pc4_q;
    assign rs_addr     = fld.src_a;
    assign rt_addr     = fld.src_b;

    brdec_fetch #(
        .PC_W     (PC_W),
        .RESET_PC (RESET_PC)
    ) u_fetch (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (npc_sel),
        .target (br_target),
        .pc     (fetch_pc)
    );

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && !stall) |=> (fetch_pc == $past(fetch_pc) + PC_STEP));

    // R4
    target_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (fetch_pc == $past(issue_pc4) + ($past({{(PC_W-IMM_W){fld.imm[IMM_W-1]}}, fld.imm}) << IMM_SHIFT)));

    // R5
    squash_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !delay_mode) |=> (!issue_valid && issue_instr == NOP_WORD));

    // R6
    delay_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && delay_mode) |=> (issue_valid && issue_instr == $past(imem_data)));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(fetch_pc) && $stable(issue_instr)));

    // R7
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!redirect && !issue_valid));
endmodule

// File: tb/brdec_unit_test.sv
`timescale 1ns/1ps
module brdec_unit_test;
    localparam logic [31:0] RST_PC = 32'h0000_1000;
    localparam logic [31:0] FILL_A = {6'h08, 5'd9, 5'd10, 16'h00AA};
    localparam logic [31:0] FILL_S = {6'h08, 5'd11, 5'd12, 16'h0155};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        delay_mode = 1'b0;
    logic [31:0] imem_data = FILL_A;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic        ex_wr_en = 1'b0;
    logic [4:0]  ex_wr_reg = '0;
    logic [31:0] fetch_pc;
    logic [4:0]  rs_addr;
    logic [4:0]  rt_addr;
    logic        issue_valid;
    logic [31:0] issue_instr;
    logic [31:0] issue_pc4;
    logic        redirect;
    logic        squash;
    logic        stall;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    brdec_unit uut (
        .clk(clk), .rst_n(rst_n), .delay_mode(delay_mode), .imem_data(imem_data),
        .rs_val(rs_val), .rt_val(rt_val), .ex_wr_en(ex_wr_en), .ex_wr_reg(ex_wr_reg),
        .fetch_pc(fetch_pc), .rs_addr(rs_addr), .rt_addr(rt_addr),
        .issue_valid(issue_valid), .issue_instr(issue_instr), .issue_pc4(issue_pc4),
        .redirect(redirect), .squash(squash), .stall(stall)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkword(input logic [5:0] op, input logic [4:0] a,
                                           input logic [4:0] b, input logic [15:0] imm);
        return {op, a, b, imm};
    endfunction

    function automatic logic [31:0] disp(input logic [15:0] imm);
        return {{16{imm[15]}}, imm} << 2;
    endfunction

    task automatic run_br(input logic [5:0] op, input logic [15:0] imm,
                          input bit eq, input bit mode);
        logic [31:0] p;
        logic [31:0] w;
        bit          tk;
        @(negedge clk);
        delay_mode = mode;
        ex_wr_en   = 1'b0;
        p = fetch_pc;
        w = mkword(op, 5'd1, 5'd2, imm);
        imem_data = w;
        @(negedge clk);
        imem_data = FILL_S;
        rs_val = 32'h0000_1234;
        rt_val = eq ? 32'h0000_1234 : 32'h0000_4321;
        tk = (op == 6'h04) ? eq : ((op == 6'h05) ? !eq : 1'b0);
        #1;
        chk("R9 rs_addr", 32'(rs_addr), 32'd1);
        chk("R9 rt_addr", 32'(rt_addr), 32'd2);
        chk("R2 issue_instr", issue_instr, w);
        chk("R2 issue_pc4", issue_pc4, p + 4);
        chk("R3 redirect", 32'(redirect), 32'(tk));
        chk("R5 squash", 32'(squash), 32'(tk && !mode));
        @(negedge clk);
        imem_data = FILL_A;
        #1;
        chk("R4 fetch_pc", fetch_pc, tk ? (p + 4 + disp(imm)) : (p + 8));
        if (tk && !mode) begin
            chk("R5 bubble valid", 32'(issue_valid), 32'd0);
            chk("R5 bubble word", issue_instr, 32'd0);
        end else begin
            chk("R6 successor valid", 32'(issue_valid), 32'd1);
            chk("R6 successor word", issue_instr, FILL_S);
        end
    endtask

    task automatic run_hz(input logic [4:0] ra, input logic [4:0] rb,
                          input logic [4:0] wr, input bit isbr, input bit mode);
        logic [31:0] p;
        logic [31:0] w;
        bit          st;
        @(negedge clk);
        delay_mode = mode;
        ex_wr_en   = 1'b0;
        p = fetch_pc;
        w = mkword(isbr ? 6'h04 : 6'h08, ra, rb, 16'd3);
        imem_data = w;
        @(negedge clk);
        imem_data = FILL_S;
        ex_wr_en  = 1'b1;
        ex_wr_reg = wr;
        rs_val = 32'd5;
        rt_val = 32'd5;
        st = isbr && (wr != 0) && (wr == ra || wr == rb);
        #1;
        if (isbr) chk("R7 stall", 32'(stall), 32'(st));
        else      chk("R8 no stall", 32'(stall), 32'd0);
        chk("R7 issue_valid", 32'(issue_valid), 32'(!st));
        chk("R7 redirect", 32'(redirect), 32'(isbr && !st));
        if (st) begin
            @(negedge clk);
            ex_wr_en = 1'b0;
            #1;
            chk("R7 pc held", fetch_pc, p + 4);
            chk("R7 word held", issue_instr, w);
            chk("R7 released", 32'(stall), 32'd0);
            chk("R7 late redirect", 32'(redirect), 32'd1);
        end
        @(negedge clk);
        imem_data = FILL_A;
        ex_wr_en  = 1'b0;
        #1;
        chk("R4 fetch_pc after hz", fetch_pc, isbr ? (p + 4 + 32'd12) : (p + 8));
        if (isbr) begin
            chk("R6 slot after stall", 32'(issue_valid), 32'(mode));
            chk("R5 word after stall", issue_instr, mode ? FILL_S : 32'd0);
        end
    endtask

    initial begin
        logic [15:0] imms [8];
        logic [5:0]  ops [3];
        logic [31:0] p;
        imms = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0040, 16'hFFC0, 16'h1235};
        ops  = '{6'h04, 6'h05, 6'h06};

        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset pc", fetch_pc, RST_PC);
        chk("R1 reset valid", 32'(issue_valid), 32'd0);
        chk("R1 reset redirect", 32'(redirect), 32'd0);
        chk("R1 reset stall", 32'(stall), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            p = fetch_pc;
            imem_data = FILL_A + 32'(k);
            @(negedge clk);
            imem_data = FILL_A;
            #1;
            chk("R2 step", fetch_pc, p + 4);
            chk("R2 valid", 32'(issue_valid), 32'd1);
            chk("R2 word", issue_instr, FILL_A + 32'(k));
            chk("R2 pc4", issue_pc4, p + 4);
        end

        for (int m = 0; m < 2; m++)
            for (int o = 0; o < 3; o++)
                for (int e = 0; e < 2; e++)
                    for (int i = 0; i < 8; i++)
                        run_br(ops[o], imms[i], e[0], m[0]);

        for (int wr = 0; wr < 8; wr++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    for (int br = 0; br < 2; br++)
                        run_hz(5'(a), 5'(b), 5'(wr), br[0], wr[0] ^ a[0]);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #500000;
        nchk++;
        nerr++;
        $display("FAIL R2 watchdog act=hung exp=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule